// File: doc/BRIEF.md
# Load/Store Port with Local Doubleword Memory

This block serves one requester that performs single loads and stores against a small on-block memory that is one doubleword (64 bits) wide. The requester raises a load or store request and presents an address, a valid flag for that address, and a byte count. It also presents a privilege flag and a line-zero flag. The block answers in two steps. First it acknowledges the address. Then, for a store, it takes one strobed data word. For a load, it returns data or raises an exception. A busy flag frames every transaction.

The block derives a byte-lane mask from the low three address bits and the byte count. It moves data between the low bytes of the port and the addressed lanes in little-endian order. An access that would spill past an 8-byte boundary, or that uses an unsupported byte count, is refused with an exception and does not touch memory. A store with the line-zero flag set clears the whole doubleword that holds the address. The doubleword is selected by address bits [3 +: log2(DEPTH)], and the higher address bits are ignored.

Top module: `lsport_mem`

## Requirements
- R1: After reset, busy_o, addr_ack_o, ld_vld_o, exc_o and exc_misalign_o are all low.
- R2: In idle, a request (ld_req_i or st_req_i) with addr_vld_i high is taken on a clock edge. From the next cycle, addr_ack_o and busy_o are both high. busy_o never rises without addr_ack_o.
- R3: For a store, addr_ack_o stays high until st_stb_i is seen for one cycle. The data is written on that edge. In the following cycle busy_o and addr_ack_o are low.
- R4: For a load, ld_vld_o rises in the cycle after the acknowledge cycle, with busy_o high. Both stay high until the requester drops its request or addr_vld_i. busy_o is low in the cycle after that.
- R5: len_i gives the byte count 1, 2, 4 or 8. Load data is right-justified and zero-extended into ld_data_o.
- R6: Memory is little-endian. Store byte k (st_data_i[8k+7:8k]) lands at address A+k. Two 2-byte stores at A and A+2 read back as one 4-byte load at A, with the first store in bits [15:0].
- R7: If address bits [2:0] plus len_i exceed 8, the access raises exc_o with exc_misalign_o high. ld_vld_o stays low and memory is not written.
- R8: A len_i value other than 1, 2, 4 or 8 raises exc_o with exc_misalign_o low. Memory is not written.
- R9: A store with zero_line_i set clears all 8 bytes of the aligned doubleword that holds the address. It ignores st_data_i and len_i, never raises an exception, and leaves other doublewords unchanged.
- R10: priv_i has no effect on what is stored or loaded.
- R11: A request with addr_vld_i low is not accepted: addr_ack_o and busy_o stay low.
- R12: ld_vld_o and exc_o are never high together, and ld_data_o is stable while ld_vld_o is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req_i | input | 1 | Load request |
| st_req_i | input | 1 | Store request |
| zero_line_i | input | 1 | With a store: clear the whole doubleword |
| priv_i | input | 1 | Privilege flag, sampled with the request |
| len_i | input | 4 | Byte count (1, 2, 4 or 8) |
| addr_i | input | 48 | Byte address |
| addr_vld_i | input | 1 | Address valid |
| st_data_i | input | 64 | Store data, low bytes used |
| st_stb_i | input | 1 | One-cycle store data strobe |
| addr_ack_o | output | 1 | Address accepted |
| busy_o | output | 1 | Transaction in progress |
| ld_vld_o | output | 1 | Load data valid |
| ld_data_o | output | 64 | Load result |
| exc_o | output | 1 | Access refused |
| exc_misalign_o | output | 1 | Exception cause is a boundary crossing |

## Verification
The bench targets the lane boundaries. These are single bytes at offsets 1 and 7, halfwords ending exactly at offset 8, and a halfword at offset 7 that crosses the boundary. A design with an off-by-one span test would either refuse the legal access or split the illegal one into a neighbouring doubleword. A store that crosses the boundary is followed by a readback, which catches a design that raises the exception but still writes lanes. The line-zero store uses a byte count of 1 and nonzero data, so a design that honoured the mask or the data would leave stale bytes behind. A neighbouring doubleword is read to catch a design that cleared too much. Paired halfword stores read back as one word expose a design with swapped lane order.

// File: rtl/lsport_mem.sv
module lsport_mem #(
  parameter int AW    = 48,
  parameter int DW    = 64,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_req_i,
  input  logic          st_req_i,
  input  logic          zero_line_i,
  input  logic          priv_i,
  input  logic [3:0]    len_i,
  input  logic [AW-1:0] addr_i,
  input  logic          addr_vld_i,
  input  logic [DW-1:0] st_data_i,
  input  logic          st_stb_i,
  output logic          addr_ack_o,
  output logic          busy_o,
  output logic          ld_vld_o,
  output logic [DW-1:0] ld_data_o,
  output logic          exc_o,
  output logic          exc_misalign_o
);
  localparam int NB   = DW / 8;
  localparam int OFFW = $clog2(NB);
  localparam int IDXW = $clog2(DEPTH);
  localparam int SPW  = OFFW + 2;

  typedef enum logic [2:0] {S_IDLE, S_ACC, S_LDONE, S_EXC, S_SDONE} state_t;

  state_t          state;
  logic [IDXW-1:0] a_idx;
  logic [OFFW-1:0] a_off;
  logic [3:0]      a_len;
  logic            a_ld, a_zero, mis_q;
  logic [DW-1:0]   ld_q;
  logic [DW-1:0]   mem [DEPTH];

  logic            req_live, accept, len_ok, misal, bad, do_write;
  logic [SPW-1:0]  span;
  logic [NB-1:0]   lmask, wmask;
  logic [DW-1:0]   wdata, rword, dmask;

  wire unused_ok = ^{priv_i, addr_i[AW-1:OFFW+IDXW]};

  assign req_live = (ld_req_i || st_req_i) && addr_vld_i;
  assign accept   = (state == S_IDLE) && req_live;

  assign len_ok = (a_len != '0) && ((a_len & (a_len - 4'd1)) == '0) && (int'(a_len) <= NB);
  assign span   = SPW'(a_off) + SPW'(a_len);
  assign misal  = int'(span) > NB;
  assign bad    = !a_zero && (!len_ok || misal);

  assign lmask = (NB'(1) << a_len) - NB'(1);
  assign wmask = a_zero ? '1 : (lmask << a_off);
  assign wdata = a_zero ? '0 : (st_data_i << {a_off, 3'b000});
  assign rword = mem[a_idx] >> {a_off, 3'b000};

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign dmask[b*8 +: 8] = {8{lmask[b]}};
  end

  assign do_write = (state == S_ACC) && !a_ld && !bad && st_stb_i;

  always_ff @(posedge clk) begin
    if (do_write) begin
      for (int b = 0; b < NB; b++)
        if (wmask[b]) mem[a_idx][b*8 +: 8] <= wdata[b*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      a_idx  <= '0;
      a_off  <= '0;
      a_len  <= '0;
      a_ld   <= 1'b0;
      a_zero <= 1'b0;
      mis_q  <= 1'b0;
      ld_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          state  <= S_ACC;
          a_idx  <= addr_i[OFFW +: IDXW];
          a_off  <= addr_i[OFFW-1:0];
          a_len  <= len_i;
          a_ld   <= ld_req_i;
          a_zero <= !ld_req_i && zero_line_i;
        end
        S_ACC: begin
          if (bad) begin
            state <= S_EXC;
            mis_q <= len_ok && misal;
          end else if (a_ld) begin
            state <= S_LDONE;
            ld_q  <= rword & dmask;
          end else if (st_stb_i) begin
            state <= S_SDONE;
          end
        end
        S_LDONE, S_EXC, S_SDONE: if (!req_live) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign addr_ack_o     = (state == S_ACC);
  assign busy_o         = (state == S_ACC) || (state == S_LDONE) || (state == S_EXC);
  assign ld_vld_o       = (state == S_LDONE);
  assign ld_data_o      = ld_q;
  assign exc_o          = (state == S_EXC);
  assign exc_misalign_o = (state == S_EXC) && mis_q;
endmodule

// File: rtl/lsport_mem_chk.sv
module lsport_mem_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_vld_i,
  input logic          addr_ack_o,
  input logic          busy_o,
  input logic          ld_vld_o,
  input logic [DW-1:0] ld_data_o,
  input logic          exc_o
);
  a_r2_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack_o |-> busy_o);

  a_r2_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> addr_ack_o);

  a_r4_ld_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_vld_o) |-> $past(addr_ack_o));

  a_r11_no_vld_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !addr_vld_i) |=> !addr_ack_o);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_vld_o && exc_o));

  a_r12_ld_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_vld_o && $past(ld_vld_o)) |-> $stable(ld_data_o));
endmodule

bind lsport_mem lsport_mem_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_vld_i(addr_vld_i), .addr_ack_o(addr_ack_o),
  .busy_o(busy_o), .ld_vld_o(ld_vld_o), .ld_data_o(ld_data_o), .exc_o(exc_o)
);

// File: tb/tb_lsport_mem.sv
module tb_lsport_mem;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_req_i = 0, st_req_i = 0, zero_line_i = 0, priv_i = 0, addr_vld_i = 0, st_stb_i = 0;
  logic [3:0]  len_i = '0;
  logic [47:0] addr_i = '0;
  logic [63:0] st_data_i = '0;
  logic addr_ack_o, busy_o, ld_vld_o, exc_o, exc_misalign_o;
  logic [63:0] ld_data_o;

  always #10 clk = ~clk;

  lsport_mem dut (.*);

  int nchk = 0, nfail = 0;
  logic [63:0] r_data;
  logic r_ack, r_busy, r_ld, r_exc, r_mis, r_hold, r_idle;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(input bit st, input logic [47:0] a, input logic [3:0] l,
                        input logic [63:0] d, input bit z, input bit p);
    @(negedge clk);
    ld_req_i = !st; st_req_i = st; zero_line_i = z; priv_i = p;
    addr_i = a; len_i = l; addr_vld_i = 1;
    @(negedge clk);
    r_ack = addr_ack_o; r_busy = busy_o;
    if (st) begin st_stb_i = 1; st_data_i = d; end
    @(negedge clk);
    st_stb_i = 0; st_data_i = '0;
    r_ld = ld_vld_o; r_exc = exc_o; r_mis = exc_misalign_o; r_data = ld_data_o;
    r_hold = 1;
    if (ld_vld_o) begin
      @(negedge clk);
      r_hold = ld_vld_o && busy_o && (ld_data_o == r_data);
    end
    ld_req_i = 0; st_req_i = 0; addr_vld_i = 0; zero_line_i = 0; priv_i = 0;
    @(negedge clk);
    r_idle = !busy_o;
  endtask

  task automatic load(input logic [47:0] a, input logic [3:0] l, input bit p);
    access(0, a, l, '0, 0, p);
  endtask

  localparam int NV = 6;
  localparam logic [47:0] T_ADDR [NV] = '{48'h00, 48'h09, 48'h12, 48'h1C, 48'h27, 48'h2E};
  localparam logic [3:0]  T_LEN  [NV] = '{4'd8, 4'd1, 4'd2, 4'd4, 4'd1, 4'd2};
  localparam logic [63:0] T_DATA [NV] = '{64'h0123456789ABCDEF, 64'hFFFFFFFFFFFFFF5A,
                                          64'h111122223333C3D4, 64'hAAAABBBBDEADBEEF,
                                          64'h0000000000000080, 64'h9999999999997E81};
  localparam logic [63:0] T_EXP  [NV] = '{64'h0123456789ABCDEF, 64'h5A, 64'hC3D4,
                                          64'hDEADBEEF, 64'h80, 64'h7E81};

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset outputs", {59'd0, busy_o, addr_ack_o, ld_vld_o, exc_o, exc_misalign_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      access(1, T_ADDR[i], T_LEN[i], T_DATA[i], 0, 0);
      chk("R2 store ack+busy", {62'd0, r_ack, r_busy}, 64'd3);
      chk("R3 store done, busy low", {63'd0, r_idle && !r_exc}, 64'd1);
      load(T_ADDR[i], T_LEN[i], 0);
      chk("R4 load valid", {62'd0, r_ld, r_hold}, 64'd3);
      chk("R5 load data", r_data, T_EXP[i]);
      chk("R4 busy low after drop", {63'd0, r_idle}, 64'd1);
    end

    access(1, 48'h40, 4'd2, 64'hBEEF, 0, 0);
    access(1, 48'h42, 4'd2, 64'hF00F, 0, 0);
    load(48'h40, 4'd4, 0);
    chk("R6 paired halves", r_data, 64'hF00FBEEF);
    load(48'h41, 4'd1, 0);
    chk("R6 byte lane 1", r_data, 64'hBE);

    access(1, 48'h40, 4'd8, 64'h8877665544332211, 0, 0);
    access(1, 48'h46, 4'd4, 64'hFFFFFFFF, 0, 0);
    chk("R7 store cross exc", {62'd0, r_exc, r_mis}, 64'd3);
    load(48'h40, 4'd8, 0);
    chk("R7 no write on exc", r_data, 64'h8877665544332211);
    load(48'h47, 4'd2, 0);
    chk("R7 load cross exc, no valid", {61'd0, r_exc, r_mis, r_ld}, 64'd6);
    load(48'h46, 4'd2, 0);
    chk("R7 halfword ends at 8 ok", {63'd0, r_ld}, 64'd1);
    chk("R7 halfword ends at 8 data", r_data, 64'h8877);

    load(48'h40, 4'd3, 0);
    chk("R8 bad length exc", {61'd0, r_exc, r_mis, r_ld}, 64'd4);
    access(1, 48'h40, 4'd5, 64'h0, 0, 0);
    chk("R8 bad length store exc", {62'd0, r_exc, r_mis}, 64'd2);
    load(48'h40, 4'd8, 0);
    chk("R8 no write on exc", r_data, 64'h8877665544332211);

    access(1, 48'h48, 4'd8, 64'hCAFEF00DCAFEF00D, 0, 0);
    access(1, 48'h45, 4'd1, 64'hFF, 1, 0);
    chk("R9 zero store no exc", {63'd0, r_exc}, 64'd0);
    load(48'h40, 4'd8, 0);
    chk("R9 doubleword cleared", r_data, 64'd0);
    load(48'h48, 4'd8, 0);
    chk("R9 neighbour kept", r_data, 64'hCAFEF00DCAFEF00D);

    access(1, 48'h50, 4'd8, 64'h5555AAAA1234FEDC, 0, 1);
    load(48'h50, 4'd8, 0);
    chk("R10 priv store", r_data, 64'h5555AAAA1234FEDC);
    load(48'h50, 4'd8, 1);
    chk("R10 priv load", r_data, 64'h5555AAAA1234FEDC);

    @(negedge clk);
    ld_req_i = 1; addr_i = 48'h50; len_i = 4'd8; addr_vld_i = 0;
    repeat (3) @(negedge clk);
    chk("R11 no vld ignored", {62'd0, addr_ack_o, busy_o}, 64'd0);
    ld_req_i = 0;
    @(negedge clk);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule